// File: doc/BRIEF.md
# Write-Through Store Queue

This block sits between a write-through data cache and main memory. Every processor store that updates the cache is also handed to this queue as an address/data pair. A memory-side controller takes the pairs out one at a time, oldest first, at whatever pace memory allows. The processor therefore continues without waiting for each memory write. It is held back only when all slots are occupied, or while a flush is in progress.

Loads must not read stale memory while a newer store to the same address is still queued. The queue compares the load address against every pending entry in the same cycle. When one or more entries match, it returns the data of the youngest matching entry. A flush request blocks new stores and reports when the queue has fully emptied.

Top module: `wt_store_queue`

## Requirements
- R1: After reset the queue is empty: `mem_valid`, `st_stall`, `ld_hit` and `flush_done` are all low.
- R2: A store is accepted on a clock edge where `st_valid` is high and `st_stall` is low. If the queue was empty, `mem_valid` is high in the following cycle.
- R3: `mem_addr`/`mem_data` always show the oldest pending entry, so memory receives stores in the order they were accepted.
- R4: An entry is removed only on an edge where `mem_valid` and `mem_ready` are both high. While `mem_valid` is high and `mem_ready` is low, `mem_addr` and `mem_data` hold their values.
- R5: With DEPTH (default 4) entries pending, `st_stall` is high and an offered store is not taken.
- R6: A store accepted on the same edge as a drain leaves the number of pending entries unchanged.
- R7: `ld_hit` is high in the same cycle whenever `ld_addr` equals the address of any pending entry. `ld_data` then carries the data of the youngest such entry.
- R8: `ld_hit` is low when no pending entry matches `ld_addr`, including when the matching store has already drained or the queue is empty.
- R9: While `flush_req` is high, `st_stall` is high and no store is accepted. `flush_done` is high exactly when `flush_req` is high and the queue is empty.
- R10: A full queue that drains one entry, with `flush_req` low, drops `st_stall` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Processor offers a store |
| st_addr | input | AW | Store address |
| st_data | input | DW | Store data |
| st_stall | output | 1 | Store cannot be accepted this cycle |
| mem_valid | output | 1 | Oldest entry available to memory |
| mem_addr | output | AW | Address of oldest entry |
| mem_data | output | DW | Data of oldest entry |
| mem_ready | input | 1 | Memory accepts the offered entry |
| ld_addr | input | AW | Address of the load being checked |
| ld_hit | output | 1 | A pending entry matches `ld_addr` |
| ld_data | output | DW | Data of youngest matching entry |
| flush_req | input | 1 | Block stores and drain |
| flush_done | output | 1 | Flush requested and queue empty |

## Verification
The hardest case to reach is a load whose address matches several pending entries while the queue has wrapped. This checks that the youngest copy is picked by age rather than by slot number. The stimulus table reaches it by filling the queue with two stores to one address and draining from the full state. It then pushes again so the write pointer wraps past the read pointer, and probes the repeated address at each step. A separate directed sequence holds the queue at two entries through three cycles of simultaneous store and drain. It then counts the remaining drains and checks which entries survived.

// File: rtl/sq_pkg.sv
package sq_pkg;

  // Next slot index with wrap at the queue depth.
  function automatic int wrap_inc(int p, int depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

  // Pending-entry count after one edge.
  function automatic int occ_step(int occ, logic push, logic pop);
    return occ + (push ? 1 : 0) - (pop ? 1 : 0);
  endfunction

  // Age of a slot relative to the read pointer: 0 = oldest.
  function automatic int slot_age(int slot, int rd, int depth);
    return (slot + depth - rd) % depth;
  endfunction

endpackage

// File: rtl/sq_ctrl.sv
module sq_ctrl #(
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [CNT_W-1:0] occ,
  output logic             full,
  output logic             empty
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      if (push) wr_ptr <= PTR_W'(sq_pkg::wrap_inc(int'(wr_ptr), DEPTH));
      if (pop)  rd_ptr <= PTR_W'(sq_pkg::wrap_inc(int'(rd_ptr), DEPTH));
      occ <= CNT_W'(sq_pkg::occ_step(int'(occ), push, pop));
    end
  end

  assign full  = (occ == CNT_W'(DEPTH));
  assign empty = (occ == '0);

endmodule

// File: rtl/sq_store.sv
module sq_store #(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [PTR_W-1:0]          wr_ptr,
  input  logic [AW-1:0]             waddr,
  input  logic [DW-1:0]             wdata,
  input  logic [PTR_W-1:0]          rd_ptr,
  output logic [AW-1:0]             head_addr,
  output logic [DW-1:0]             head_data,
  output logic [DEPTH-1:0][AW-1:0]  addr_q,
  output logic [DEPTH-1:0][DW-1:0]  data_q
);

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        addr_q[s] <= '0;
        data_q[s] <= '0;
      end else if (we && (int'(wr_ptr) == s)) begin
        addr_q[s] <= waddr;
        data_q[s] <= wdata;
      end
    end
  end

  assign head_addr = addr_q[rd_ptr];
  assign head_data = data_q[rd_ptr];

endmodule

// File: rtl/sq_match.sv
module sq_match #(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [DEPTH-1:0][AW-1:0] addr_q,
  input  logic [DEPTH-1:0][DW-1:0] data_q,
  input  logic [PTR_W-1:0]         rd_ptr,
  input  logic [CNT_W-1:0]         occ,
  input  logic [AW-1:0]            ld_addr,
  output logic                     hit,
  output logic [DW-1:0]            hit_data
);

  always_comb begin
    int best;
    int age;
    best     = -1;
    hit      = 1'b0;
    hit_data = '0;
    for (int s = 0; s < DEPTH; s++) begin
      age = sq_pkg::slot_age(s, int'(rd_ptr), DEPTH);
      if ((age < int'(occ)) && (addr_q[s] == ld_addr) && (age > best)) begin
        best     = age;
        hit      = 1'b1;
        hit_data = data_q[s];
      end
    end
  end

endmodule

// File: rtl/wt_store_queue.sv
module wt_store_queue #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_valid,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  output logic          st_stall,
  output logic          mem_valid,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_data,
  input  logic          mem_ready,
  input  logic [AW-1:0] ld_addr,
  output logic          ld_hit,
  output logic [DW-1:0] ld_data,
  input  logic          flush_req,
  output logic          flush_done
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic                     full, empty;
  logic                     push_evt, pop_evt;
  logic [PTR_W-1:0]         wr_ptr, rd_ptr;
  logic [CNT_W-1:0]         occ;
  logic [DEPTH-1:0][AW-1:0] addr_q;
  logic [DEPTH-1:0][DW-1:0] data_q;

  assign st_stall   = full | flush_req;
  assign push_evt   = st_valid & ~st_stall;
  assign mem_valid  = ~empty;
  assign pop_evt    = mem_valid & mem_ready;
  assign flush_done = flush_req & empty;

  sq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .push(push_evt), .pop(pop_evt),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .occ(occ), .full(full), .empty(empty)
  );

  sq_store #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .we(push_evt), .wr_ptr(wr_ptr),
    .waddr(st_addr), .wdata(st_data), .rd_ptr(rd_ptr),
    .head_addr(mem_addr), .head_data(mem_data),
    .addr_q(addr_q), .data_q(data_q)
  );

  sq_match #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_match (
    .addr_q(addr_q), .data_q(data_q), .rd_ptr(rd_ptr), .occ(occ),
    .ld_addr(ld_addr), .hit(ld_hit), .hit_data(ld_data)
  );

endmodule

// File: rtl/sq_checker.sv
module sq_checker #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             push_evt,
  input logic             pop_evt,
  input logic [CNT_W-1:0] occ,
  input logic             st_stall,
  input logic             mem_valid,
  input logic             mem_ready,
  input logic [AW-1:0]    mem_addr,
  input logic [DW-1:0]    mem_data,
  input logic             ld_hit,
  input logic             flush_req,
  input logic             flush_done
);

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data))); // R4

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == CNT_W'(DEPTH)) |-> st_stall); // R5

  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CNT_W'(DEPTH)); // R5

  AST_BALANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (push_evt && pop_evt) |=> (occ == $past(occ))); // R6

  AST_EMPTY_NOHIT: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_valid |-> !ld_hit); // R8

  AST_FLUSH_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> !push_evt); // R9

  AST_FLUSH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    flush_done |-> (!mem_valid && flush_req)); // R9

  AST_STALL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    ((occ == CNT_W'(DEPTH)) && pop_evt && !flush_req) |=> !st_stall); // R10

endmodule

bind wt_store_queue sq_checker #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .push_evt(push_evt), .pop_evt(pop_evt), .occ(occ),
  .st_stall(st_stall), .mem_valid(mem_valid), .mem_ready(mem_ready),
  .mem_addr(mem_addr), .mem_data(mem_data), .ld_hit(ld_hit),
  .flush_req(flush_req), .flush_done(flush_done)
);

// File: tb/wt_store_queue_test.sv
module wt_store_queue_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        st_valid = 1'b0;
  logic [31:0] st_addr = '0;
  logic [31:0] st_data = '0;
  logic        st_stall;
  logic        mem_valid;
  logic [31:0] mem_addr;
  logic [31:0] mem_data;
  logic        mem_ready = 1'b0;
  logic [31:0] ld_addr = '0;
  logic        ld_hit;
  logic [31:0] ld_data;
  logic        flush_req = 1'b0;
  logic        flush_done;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  wt_store_queue uut (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr),
    .st_data(st_data), .st_stall(st_stall), .mem_valid(mem_valid),
    .mem_addr(mem_addr), .mem_data(mem_data), .mem_ready(mem_ready),
    .ld_addr(ld_addr), .ld_hit(ld_hit), .ld_data(ld_data),
    .flush_req(flush_req), .flush_done(flush_done)
  );

  typedef struct packed {
    logic       sv;
    logic [7:0] a;
    logic [7:0] d;
    logic       rdy;
    logic [7:0] la;
    logic       e_stall;
    logic       e_mv;
    logic [7:0] e_ma;
    logic       e_hit;
    logic [7:0] e_ld;
  } vec_t;

  // Expected columns describe outputs in the cycle the row is applied.
  localparam vec_t VEC [14] = '{
    '{1'b1, 8'h10, 8'h01, 1'b0, 8'h10, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00},
    '{1'b1, 8'h20, 8'h02, 1'b0, 8'h10, 1'b0, 1'b1, 8'h10, 1'b1, 8'h01},
    '{1'b1, 8'h10, 8'h03, 1'b0, 8'h20, 1'b0, 1'b1, 8'h10, 1'b1, 8'h02},
    '{1'b1, 8'h30, 8'h04, 1'b0, 8'h10, 1'b0, 1'b1, 8'h10, 1'b1, 8'h03},
    '{1'b1, 8'h40, 8'h05, 1'b0, 8'h30, 1'b1, 1'b1, 8'h10, 1'b1, 8'h04},
    '{1'b1, 8'h40, 8'h05, 1'b1, 8'hFF, 1'b1, 1'b1, 8'h10, 1'b0, 8'h00},
    '{1'b1, 8'h40, 8'h05, 1'b0, 8'h10, 1'b0, 1'b1, 8'h20, 1'b1, 8'h03},
    '{1'b0, 8'h00, 8'h00, 1'b1, 8'h20, 1'b1, 1'b1, 8'h20, 1'b1, 8'h02},
    '{1'b1, 8'h50, 8'h06, 1'b1, 8'h20, 1'b0, 1'b1, 8'h10, 1'b0, 8'h00},
    '{1'b0, 8'h00, 8'h00, 1'b1, 8'h50, 1'b0, 1'b1, 8'h30, 1'b1, 8'h06},
    '{1'b0, 8'h00, 8'h00, 1'b1, 8'h30, 1'b0, 1'b1, 8'h40, 1'b0, 8'h00},
    '{1'b0, 8'h00, 8'h00, 1'b0, 8'h50, 1'b0, 1'b1, 8'h50, 1'b1, 8'h06},
    '{1'b0, 8'h00, 8'h00, 1'b1, 8'h50, 1'b0, 1'b1, 8'h50, 1'b1, 8'h06},
    '{1'b0, 8'h00, 8'h00, 1'b1, 8'h50, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00}
  };

  function automatic logic [31:0] mk_addr(logic [7:0] v);
    return {24'hA50000, v};
  endfunction

  function automatic logic [31:0] mk_data(logic [7:0] v);
    return {24'h5A0000, v};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Apply inputs after a falling edge, leave time to settle before checks.
  task automatic apply(input logic sv, input logic [31:0] a, input logic [31:0] d,
                       input logic rdy, input logic [31:0] la, input logic fl);
    @(negedge clk);
    st_valid  = sv;
    st_addr   = a;
    st_data   = d;
    mem_ready = rdy;
    ld_addr   = la;
    flush_req = fl;
    #2;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int drains;
    logic [31:0] first_out;

    // R1: reset state
    repeat (3) @(posedge clk);
    apply(1'b0, '0, '0, 1'b0, mk_addr(8'h00), 1'b0);
    chk("R1 mem_valid", {31'b0, mem_valid}, 32'd0);
    chk("R1 st_stall", {31'b0, st_stall}, 32'd0);
    chk("R1 ld_hit", {31'b0, ld_hit}, 32'd0);
    chk("R1 flush_done", {31'b0, flush_done}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // Table walk: fill, full stall, release, wrap, forwarding, drain
    for (int i = 0; i < 14; i++) begin
      apply(VEC[i].sv, mk_addr(VEC[i].a), mk_data(VEC[i].d), VEC[i].rdy,
            mk_addr(VEC[i].la), 1'b0);
      chk("R5/R10 st_stall", {31'b0, st_stall}, {31'b0, VEC[i].e_stall});
      chk("R2 mem_valid", {31'b0, mem_valid}, {31'b0, VEC[i].e_mv});
      if (VEC[i].e_mv) begin
        chk("R3 mem_addr", mem_addr, mk_addr(VEC[i].e_ma));
        chk("R3 mem_data", mem_data, mk_data(VEC[i].e_ma == 8'h10 ? (i < 6 ? 8'h01 : 8'h03)
                                     : VEC[i].e_ma == 8'h20 ? 8'h02
                                     : VEC[i].e_ma == 8'h30 ? 8'h04
                                     : VEC[i].e_ma == 8'h40 ? 8'h05 : 8'h06));
      end
      chk(VEC[i].e_hit ? "R7 ld_hit" : "R8 ld_hit", {31'b0, ld_hit}, {31'b0, VEC[i].e_hit});
      if (VEC[i].e_hit) chk("R7 ld_data", ld_data, mk_data(VEC[i].e_ld));
    end

    // R6: two entries, three cycles of store plus drain, then count drains
    apply(1'b1, mk_addr(8'h61), mk_data(8'h61), 1'b0, mk_addr(8'hFF), 1'b0);
    apply(1'b1, mk_addr(8'h62), mk_data(8'h62), 1'b0, mk_addr(8'hFF), 1'b0);
    for (int k = 0; k < 3; k++) begin
      apply(1'b1, mk_addr(8'h63 + 8'(k)), mk_data(8'h63 + 8'(k)), 1'b1, mk_addr(8'hFF), 1'b0);
    end
    apply(1'b0, '0, '0, 1'b0, mk_addr(8'hFF), 1'b0);
    first_out = mem_addr;
    chk("R3 oldest after overlap", first_out, mk_addr(8'h64));
    drains = 0;
    for (int k = 0; k < 8; k++) begin
      apply(1'b0, '0, '0, 1'b1, mk_addr(8'hFF), 1'b0);
      if (mem_valid) drains++;
    end
    chk("R6 remaining entries", 32'(drains), 32'd2);

    // R9 and R4: flush with memory held off
    apply(1'b1, mk_addr(8'h71), mk_data(8'h71), 1'b0, mk_addr(8'hFF), 1'b0);
    apply(1'b1, mk_addr(8'h72), mk_data(8'h72), 1'b0, mk_addr(8'hFF), 1'b0);
    apply(1'b1, mk_addr(8'h73), mk_data(8'h73), 1'b0, mk_addr(8'h73), 1'b1);
    chk("R9 stall in flush", {31'b0, st_stall}, 32'd1);
    chk("R9 not done yet", {31'b0, flush_done}, 32'd0);
    chk("R4 head before hold", mem_addr, mk_addr(8'h71));
    apply(1'b1, mk_addr(8'h73), mk_data(8'h73), 1'b0, mk_addr(8'h73), 1'b1);
    chk("R4 addr held", mem_addr, mk_addr(8'h71));
    chk("R4 data held", mem_data, mk_data(8'h71));
    chk("R9 blocked store absent", {31'b0, ld_hit}, 32'd0);
    apply(1'b1, mk_addr(8'h73), mk_data(8'h73), 1'b1, mk_addr(8'h73), 1'b1);
    apply(1'b1, mk_addr(8'h73), mk_data(8'h73), 1'b1, mk_addr(8'h73), 1'b1);
    chk("R9 last entry", mem_addr, mk_addr(8'h72));
    apply(1'b1, mk_addr(8'h73), mk_data(8'h73), 1'b1, mk_addr(8'h73), 1'b1);
    chk("R9 flush_done", {31'b0, flush_done}, 32'd1);
    chk("R9 empty", {31'b0, mem_valid}, 32'd0);
    chk("R8 no hit after flush", {31'b0, ld_hit}, 32'd0);
    apply(1'b0, '0, '0, 1'b0, mk_addr(8'hFF), 1'b0);
    chk("R9 released stall", {31'b0, st_stall}, 32'd0);
    chk("R9 done drops", {31'b0, flush_done}, 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule